// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a field-configurable AND-OR array. Eight dedicated inputs and ten bidirectional lines form eighteen array variables. Every product term can use each variable in true form, complement form, or not at all. Thirty-two logic terms can be wired freely into ten OR sums. Each sum passes through a per-line polarity XOR, so a line can produce either AND-OR or AND-NOR logic. Ten further product terms act as per-line output enables. A line whose enable term is false is released, and its external value is fed back into the array. The same block can therefore act as anything from eighteen inputs with no outputs to eight inputs with ten outputs.

The whole configuration is a single 1842-bit word. It is shifted in one bit per clock while a load strobe is held high. The array itself is purely combinational once the word is in place. Each pin is modelled as three signals: an input value, an output value and an output enable. The enclosing pad logic builds the tristate from them.

Top module: `sop_array`

## Requirements
- R1: While `rstN` is low, every bit of `ioOe` is 0 and the configuration word is cleared. After release, the empty configuration gives `ioOe` = all ones and `ioOut` = all zeros, because an empty enable term is 1, an empty sum is 0 and the polarity bits are 0.
- R2: On each rising clock edge with `cfgLoad` high, the configuration word moves up one place and `cfgData` enters bit 0. After 1842 such edges, the first bit sent is in bit 1841, so the word is loaded MSB-first.
- R3: The configuration word has three fields. Bits [9:0] are the polarity bits, with bit k belonging to line k. Bit 10 + 32·g + p connects logic term p to sum g. Bit 330 + 36·t + 2·v connects the true literal of variable v to term t, and the next bit up connects its complement. Terms 0–31 are logic terms; term 32 + k is the enable term of line k. Variables 0–7 are `dIn[0..7]` and variable 8 + k is line k.
- R4: A product term is the AND of its connected literals. A term with no literal is 1. A term with both literals of the same variable is 0.
- R5: Each sum is the OR of its connected logic terms. A sum with no term connected is 0.
- R6: `ioOut[k]` is sum k XORed with polarity bit k.
- R7: `ioOe[k]` equals enable term k, except that it is forced to 0 in any cycle where `cfgLoad` is high.
- R8: The array sees line k as `ioIn[k]` when `ioOe[k]` is 0, and as the block's own `ioOut[k]` when `ioOe[k]` is 1.
- R9: While `cfgLoad` is low, the configuration word does not change, whatever `cfgData` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration shift register |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Shift enable for the configuration; also forces all enables off |
| cfgData | input | 1 | Serial configuration bit |
| dIn | input | 8 | Dedicated array inputs |
| ioIn | input | 10 | External value seen on each bidirectional line |
| ioOut | output | 10 | Polarity-adjusted sum driven onto each line |
| ioOe | output | 10 | Output enable for each line |

## Verification
A single misplaced or stale configuration bit acts like a wrong fuse. It shows up as soon as the input vector exercises that literal, term or sum: one enable or output differs from the reference model, with no clock delay. Such a fault can therefore hide until the right input pattern arrives. For that reason the bench sweeps every dedicated-input combination for its directed configurations, and it drives random vectors through randomly built configurations. A slip in the shift order moves every field at once, so almost any check that follows the load exposes it. A fault in the feedback path appears only when a term uses a line variable, so the directed feedback case drives the external pin value opposite to the line's own driven value.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Default geometry of the array
  localparam int DefNumIn = 8;
  localparam int DefNumIo = 10;
  localparam int DefNumLt = 32;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // advance the configuration shift register
    logic holdOff;   // force every output enable low
  } ctrl_strobe_t;

endpackage

// File: rtl/sop_ctrl.sv
module sop_ctrl
  import sop_pkg::*;
(
  input  logic         rstN,
  input  logic         cfgLoad,
  output ctrl_strobe_t strobe
);

  always_comb begin
    strobe.shiftEn = cfgLoad;
    // enables stay off while the configuration is in flux or under reset
    strobe.holdOff = cfgLoad | ~rstN;
  end

endmodule

// File: rtl/sop_cfg_shift.sv
module sop_cfg_shift #(
  parameter int CfgW = 1842
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            shiftEn,
  input  logic            serIn,
  output logic [CfgW-1:0] cfgBits
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgBits <= '0;
    end else if (shiftEn) begin
      cfgBits <= {cfgBits[CfgW-2:0], serIn};
    end
  end

endmodule

// File: rtl/sop_planes.sv
module sop_planes #(
  parameter  int NumIn  = 8,
  parameter  int NumIo  = 10,
  parameter  int NumLt  = 32,
  localparam int NumVar = NumIn + NumIo,
  localparam int NumPt  = NumLt + NumIo,
  localparam int TermW  = 2 * NumVar,
  localparam int PolLsb = 0,
  localparam int OrLsb  = PolLsb + NumIo,
  localparam int AndLsb = OrLsb + NumIo * NumLt,
  localparam int CfgW   = AndLsb + NumPt * TermW
) (
  input  logic [CfgW-1:0]  cfgBits,
  input  logic             holdOff,
  input  logic [NumIn-1:0] dIn,
  input  logic [NumIo-1:0] ioIn,
  output logic [NumIo-1:0] ioOut,
  output logic [NumIo-1:0] ioOe
);

  logic [NumVar-1:0] varVal;
  logic [NumPt-1:0]  termVal;
  logic [NumIo-1:0]  sumVal;
  logic [NumIo-1:0]  lineFb;

  assign varVal = {lineFb, dIn};

  // AND plane: each term kills itself on any connected literal that is false
  for (genvar t = 0; t < NumPt; t++) begin : gTerm
    logic hit;
    always_comb begin
      hit = 1'b1;
      for (int v = 0; v < NumVar; v++) begin
        if (cfgBits[AndLsb + t*TermW + 2*v] && !varVal[v]) hit = 1'b0;
        if (cfgBits[AndLsb + t*TermW + 2*v + 1] && varVal[v]) hit = 1'b0;
      end
    end
    assign termVal[t] = hit;
  end

  // OR plane, polarity stage, enables and feedback per line
  for (genvar g = 0; g < NumIo; g++) begin : gLine
    assign sumVal[g] = |(termVal[NumLt-1:0] & cfgBits[OrLsb + g*NumLt +: NumLt]);
    assign ioOut[g]  = sumVal[g] ^ cfgBits[PolLsb + g];
    assign ioOe[g]   = termVal[NumLt + g] & ~holdOff;
    assign lineFb[g] = ioOe[g] ? ioOut[g] : ioIn[g];
  end

endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_pkg::*;
#(
  parameter  int NumIn  = DefNumIn,
  parameter  int NumIo  = DefNumIo,
  parameter  int NumLt  = DefNumLt,
  localparam int CfgW   = NumIo + NumIo * NumLt + (NumLt + NumIo) * 2 * (NumIn + NumIo)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic             cfgData,
  input  logic [NumIn-1:0] dIn,
  input  logic [NumIo-1:0] ioIn,
  output logic [NumIo-1:0] ioOut,
  output logic [NumIo-1:0] ioOe
);

  ctrl_strobe_t    strobe;
  logic [CfgW-1:0] cfgBits;

  sop_ctrl uCtrl (
    .rstN    (rstN),
    .cfgLoad (cfgLoad),
    .strobe  (strobe)
  );

  sop_cfg_shift #(.CfgW(CfgW)) uCfg (
    .clk     (clk),
    .rstN    (rstN),
    .shiftEn (strobe.shiftEn),
    .serIn   (cfgData),
    .cfgBits (cfgBits)
  );

  sop_planes #(.NumIn(NumIn), .NumIo(NumIo), .NumLt(NumLt)) uPlanes (
    .cfgBits (cfgBits),
    .holdOff (strobe.holdOff),
    .dIn     (dIn),
    .ioIn    (ioIn),
    .ioOut   (ioOut),
    .ioOe    (ioOe)
  );

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
  parameter int CfgW  = 1842,
  parameter int NumIo = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgLoad,
  input logic             cfgData,
  input logic [NumIo-1:0] ioOe,
  input logic [CfgW-1:0]  cfgBits
);

  // R1: the configuration comes out of reset empty
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cfgBits == '0));

  // R2: a load edge moves the word up and takes the serial bit at the bottom
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> (cfgBits[0] == $past(cfgData)) &&
                (cfgBits[CfgW-1:1] == $past(cfgBits[CfgW-2:0])));

  // R7: no line is driven while loading
  p_hold_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |-> (ioOe == '0));

  // R9: the word is frozen outside loading
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> $stable(cfgBits));

endmodule

bind sop_array sop_array_chk #(.CfgW(CfgW), .NumIo(NumIo)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .cfgLoad (cfgLoad),
  .cfgData (cfgData),
  .ioOe    (ioOe),
  .cfgBits (cfgBits)
);

// File: tb/tb_sop_array.sv
module tb_sop_array;

  localparam int NIN = 8;
  localparam int NIO = 10;
  localparam int NLT = 32;
  localparam int NVAR = NIN + NIO;
  localparam int NPT = NLT + NIO;
  localparam int TW = 2 * NVAR;
  localparam int ORB = NIO;
  localparam int ANDB = ORB + NIO * NLT;
  localparam int CW = ANDB + NPT * TW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic cfgData = 1'b0;
  logic [NIN-1:0] dIn = '0;
  logic [NIO-1:0] ioIn = '0;
  logic [NIO-1:0] ioOut;
  logic [NIO-1:0] ioOe;

  int nChecks = 0;
  int nFail = 0;
  logic [CW-1:0] img;

  always #5 clk = ~clk;

  sop_array dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgData(cfgData),
    .dIn(dIn), .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe)
  );

  function automatic int litIdx(int t, int v, bit neg);
    return ANDB + t*TW + 2*v + int'(neg);
  endfunction

  function automatic int orIdx(int g, int p);
    return ORB + g*NLT + p;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural model, iterated to settle acyclic feedback
  task automatic refEval(input logic [CW-1:0] c, input logic [NIN-1:0] d,
                         input logic [NIO-1:0] pin, input bit loading,
                         output logic [NIO-1:0] o, output logic [NIO-1:0] e);
    logic [NIO-1:0] lines = pin;
    logic [NPT-1:0] pt;
    logic [NVAR-1:0] x;
    o = '0; e = '0;
    for (int it = 0; it < 12; it++) begin
      x = {lines, d};
      for (int t = 0; t < NPT; t++) begin
        pt[t] = 1'b1;
        for (int v = 0; v < NVAR; v++) begin
          if (c[litIdx(t, v, 0)] && !x[v]) pt[t] = 1'b0;
          if (c[litIdx(t, v, 1)] && x[v]) pt[t] = 1'b0;
        end
      end
      for (int k = 0; k < NIO; k++) begin
        logic s = 1'b0;
        for (int p = 0; p < NLT; p++) if (c[orIdx(k, p)] && pt[p]) s = 1'b1;
        o[k] = s ^ c[k];
        e[k] = pt[NLT + k] & ~loading;
        lines[k] = e[k] ? o[k] : pin[k];
      end
    end
  endtask

  task automatic loadCfg(input logic [CW-1:0] c, input bit watchHold);
    @(negedge clk);
    cfgLoad = 1'b1;
    for (int i = CW-1; i >= 0; i--) begin
      cfgData = c[i];
      if (watchHold && i == CW/2) begin
        #2;
        check("R7 enables held off during load", 32'(ioOe), 32'h0);
      end
      @(negedge clk);
    end
    cfgLoad = 1'b0;
  endtask

  task automatic checkModel(string req, logic [NIN-1:0] d, logic [NIO-1:0] pin);
    logic [NIO-1:0] eo, ee;
    @(negedge clk);
    dIn = d; ioIn = pin;
    #2;
    refEval(img, d, pin, 1'b0, eo, ee);
    check(req, {12'h0, ioOe, ioOut}, {12'h0, ee, eo});
  endtask

  task automatic testReset();
    rstN = 1'b0;
    #23;
    check("R1 enables low during reset", 32'(ioOe), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    check("R1 empty config enables", 32'(ioOe), 32'h3ff);
    check("R1 empty config outputs", 32'(ioOut), 32'h0);
  endtask

  task automatic testEmpty();
    img = '0;
    img[orIdx(0, 0)] = 1'b1;                          // empty term -> 1
    img[litIdx(3, 0, 0)] = 1'b1; img[litIdx(3, 0, 1)] = 1'b1;
    img[orIdx(3, 3)] = 1'b1;                          // contradictory term -> 0
    img[orIdx(4, 3)] = 1'b1; img[4] = 1'b1;           // inverted 0 -> 1
    img[2] = 1'b1;                                    // inverted empty sum
    img[litIdx(NLT+9, 1, 0)] = 1'b1; img[litIdx(NLT+9, 1, 1)] = 1'b1;
    loadCfg(img, 1'b1);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      dIn = (i == 0) ? 8'h00 : 8'hff; ioIn = '0;
      #2;
      check("R4 R5 R6 empty and contradictory terms", 32'(ioOut), 32'h015);
      check("R4 R7 contradictory enable term", 32'(ioOe), 32'h1ff);
    end
  endtask

  task automatic testAndOr();
    img = '0;
    img[litIdx(1, 0, 0)] = 1'b1; img[litIdx(1, 1, 1)] = 1'b1;
    img[litIdx(2, 2, 0)] = 1'b1; img[litIdx(2, 7, 0)] = 1'b1;
    img[orIdx(0, 1)] = 1'b1; img[orIdx(0, 2)] = 1'b1;
    img[orIdx(1, 1)] = 1'b1; img[orIdx(1, 2)] = 1'b1; img[1] = 1'b1;
    img[orIdx(5, 2)] = 1'b1;
    loadCfg(img, 1'b0);
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dv = 8'(d);
      logic s, t2;
      logic [NIO-1:0] exp = '0;
      t2 = dv[2] & dv[7];
      s = (dv[0] & ~dv[1]) | t2;
      exp[0] = s; exp[1] = ~s; exp[5] = t2;
      @(negedge clk);
      dIn = dv; ioIn = 10'($urandom);
      #2;
      check("R5 R6 AND-OR sweep", 32'(ioOut), 32'(exp));
    end
  endtask

  task automatic testEnable();
    logic [7:0] pats [4] = '{8'h00, 8'h80, 8'h40, 8'hc0};
    img = '0;
    for (int k = 0; k < NIO; k++) begin
      img[orIdx(k, 0)] = 1'b1;
      if (k % 2 == 0) img[litIdx(NLT+k, 7, 0)] = 1'b1;
      else begin
        img[litIdx(NLT+k, 7, 1)] = 1'b1; img[litIdx(NLT+k, 6, 0)] = 1'b1;
      end
    end
    loadCfg(img, 1'b0);
    foreach (pats[i]) begin
      logic ev = pats[i][7];
      logic od = ~pats[i][7] & pats[i][6];
      @(negedge clk);
      dIn = pats[i]; ioIn = '0;
      #2;
      check("R7 enable terms", 32'(ioOe), 32'({5{od, ev}}));
      check("R5 outputs with empty term", 32'(ioOut), 32'h3ff);
    end
  endtask

  task automatic testFeedback();
    img = '0;
    img[litIdx(NLT+0, 0, 0)] = 1'b1; img[litIdx(NLT+0, 0, 1)] = 1'b1; // line 0 off
    img[litIdx(0, 8, 0)] = 1'b1;  img[orIdx(1, 0)] = 1'b1;           // out1 = line0
    img[litIdx(1, 0, 0)] = 1'b1;  img[orIdx(2, 1)] = 1'b1;           // out2 = dIn0
    img[litIdx(2, 10, 0)] = 1'b1; img[orIdx(3, 2)] = 1'b1;           // out3 = line2
    loadCfg(img, 1'b0);
    for (int i = 0; i < 4; i++) begin
      logic a = i[0];
      logic b = i[1];
      @(negedge clk);
      dIn = {7'h0, b}; ioIn = {7'h0, ~b, 1'b0, a};
      #2;
      check("R8 released line reads pin", 32'(ioOut[1]), 32'(a));
      check("R8 driven line reads own value", 32'(ioOut[3]), 32'(b));
    end
  endtask

  task automatic testHold();
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      cfgData = 1'($urandom);
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++) checkModel("R9 config unchanged without load", 8'($urandom), 10'($urandom));
  endtask

  task automatic buildRandom();
    logic [NIO-1:0] inMask = 10'($urandom);
    img = '0;
    for (int k = 0; k < NIO; k++) begin
      img[k] = 1'($urandom);
      if (inMask[k]) begin
        img[litIdx(NLT+k, 0, 0)] = 1'b1; img[litIdx(NLT+k, 0, 1)] = 1'b1;
      end else if ($urandom % 2 == 0) begin
        img[litIdx(NLT+k, $urandom % NIN, 1'($urandom))] = 1'b1;
      end
      for (int p = 0; p < NLT; p++) if ($urandom % 4 == 0) img[orIdx(k, p)] = 1'b1;
    end
    for (int t = 0; t < NLT; t++)
      for (int v = 0; v < NVAR; v++)
        if (v < NIN || inMask[v-NIN]) begin
          int r = $urandom % 10;
          if (r == 0) img[litIdx(t, v, 0)] = 1'b1;
          else if (r == 1) img[litIdx(t, v, 1)] = 1'b1;
        end
  endtask

  task automatic testRandom();
    for (int n = 0; n < 6; n++) begin
      buildRandom();
      loadCfg(img, 1'b1);
      for (int i = 0; i < 48; i++) checkModel("R3 random config vs model", 8'($urandom), 10'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    testReset();
    testEmpty();
    testAndOr();
    testEnable();
    testFeedback();
    testHold();
    testRandom();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule